// File: doc/BRIEF.md
# Dual-Width Host Bus Front End

This block is the host-facing edge of a character display controller. A host drives an asynchronous strobe-qualified parallel bus: a register-select line, a read/write line, an enable strobe and an eight-bit data bus. The block brings these into the controller clock domain with a two-stage synchronizer. It commits each transfer on the falling edge of the enable strobe.

Writes with select low are passed on as instruction bytes. Writes with select high are passed on as data bytes. Each completed byte is handed to the instruction execution unit as a one-cycle pulse. Reads with select low return a status byte: the busy flag from the execution unit in bit 7 and its seven-bit address counter below it. Reads with select high return the execution unit's data byte, and the block pulses a pop strobe so that the unit can advance to the next location.

The bus runs either eight bits wide or four bits wide. In four-bit mode only the upper four data lines are used, and each byte takes two strobes, upper half first. The width is changed at run time. The block watches for the configuration instruction among the instruction bytes it assembles and takes the new width from that instruction's width bit.

Top module: `mpu_bus_front`

## Requirements
- R1: After reset the bus is eight bits wide and the nibble phase is "upper". `cmd_valid`, `rdata_pop` and `bus_d_oe` are low, and `bus_d_out` is zero.
- R2: In eight-bit mode, a strobe with `bus_rs`=0 and `bus_rw`=0 gives one `cmd_valid` pulse with `cmd_is_data`=0 and `cmd_byte` equal to the bus byte. The pulse is seen in the third clock cycle after the cycle in which `bus_en` falls.
- R3: A write with `bus_rs`=1 is delivered in the same way with `cmd_is_data`=1.
- R4: While `bus_en` is high with `bus_rs`=0 and `bus_rw`=1, `bus_d_out` carries `{exec_busy, exec_addr}`, busy in bit 7. This holds from the second clock edge after `bus_en` rises.
- R5: A read with `bus_rs`=1 drives `exec_rdata` on `bus_d_out`. When the read completes, `rdata_pop` pulses once, with the same timing as R2. Status reads and writes never pulse `rdata_pop`.
- R6: In four-bit mode a byte is taken from `bus_d_in[7:4]` over two strobes, upper half first. `cmd_valid` pulses only after the second strobe and never after the first.
- R7: In four-bit mode a read returns the upper half of the selected byte on `bus_d_out[7:4]` on the first strobe and the lower half on the second. `bus_d_out[3:0]` is zero during these reads. A data read pops only after the second strobe.
- R8: An instruction byte whose bits 7:5 are 001 sets the width from bit 4 (1 = eight bits, 0 = four bits). The nibble phase returns to "upper" when this happens. The new width applies from the next strobe.
- R9: `bus_d_oe` is high only while the synchronized `bus_en` is high and `bus_rw` is 1. It stays low during writes.
- R10: The instruction register is write-only. A read with `bus_rs`=0 returns the status byte, never the last instruction written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Host enable strobe, asynchronous |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_d_in | input | 8 | Data bus as driven by the host |
| bus_d_out | output | 8 | Data returned to the host |
| bus_d_oe | output | 1 | Output enable for the bus pad drivers |
| exec_busy | input | 1 | Busy flag from the execution unit |
| exec_addr | input | 7 | Address counter from the execution unit |
| exec_rdata | input | 8 | Data byte offered for host reads |
| cmd_valid | output | 1 | One-cycle pulse: a written byte is complete |
| cmd_is_data | output | 1 | Register select of the delivered byte |
| cmd_byte | output | 8 | Delivered byte |
| rdata_pop | output | 1 | One-cycle pulse: a data read has completed |

## Verification
Both `cmd_valid` and `rdata_pop` fall due exactly three clock edges after the cycle in which the host drops `bus_en`: two synchronizer stages, then the commit register. The driver records the cycle counter at the drop and pushes that due cycle into the scoreboard. The monitor checks each pulse against the cycle it carries, and it also flags any pulse that was not expected, including one after a lone first nibble.

Read data and output enable become valid two edges after `bus_en` rises. The driver samples them on the falling clock edge after the fourth rising edge, while the strobe is still high.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
    parameter int DW = 8;                 // host data bus width
    parameter int AW = 7;                 // address counter width
    localparam int NW = DW / 2;           // nibble width
    // configuration instruction: bits [DW-1:DW-3] == 3'b001, width bit below them
    localparam logic [2:0] CFG_OPC = 3'b001;
    localparam int CFG_WBIT = DW - 4;

    typedef struct packed {
        logic          en;
        logic          rs;
        logic          rw;
        logic [DW-1:0] d;
    } bus_smp_t;
endpackage

// File: rtl/mbi_sync.sv
module mbi_sync
    import mbi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t raw,
    output bus_smp_t smp,
    output logic     fall
);
    typedef struct packed {
        bus_smp_t [STAGES-1:0] pipe;
        logic                  e_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.e_prev = st_q.pipe[STAGES-1].en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp  = st_q.pipe[STAGES-1];
    assign fall = st_q.e_prev & ~st_q.pipe[STAGES-1].en;
endmodule

// File: rtl/mbi_assembler.sv
module mbi_assembler
    import mbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          rs,
    input  logic          rw,
    input  logic [DW-1:0] din,
    output logic          valid,
    output logic          is_data,
    output logic [DW-1:0] dat,
    output logic          pop,
    output logic          wide,
    output logic          lo_phase
);
    typedef struct packed {
        logic          wide;
        logic          lo_phase;
        logic [NW-1:0] hi_nib;
        logic          valid;
        logic          is_data;
        logic [DW-1:0] dat;
        logic          pop;
    } asm_st_t;

    asm_st_t st_d, st_q;
    logic          complete;
    logic [DW-1:0] full_byte;

    always_comb begin
        complete  = st_q.wide | st_q.lo_phase;
        full_byte = st_q.wide ? din : {st_q.hi_nib, din[DW-1:NW]};
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.pop   = 1'b0;
        if (fall) begin
            if (!complete) begin
                st_d.hi_nib   = din[DW-1:NW];
                st_d.lo_phase = 1'b1;
            end else begin
                st_d.lo_phase = 1'b0;
                if (!rw) begin
                    st_d.valid   = 1'b1;
                    st_d.is_data = rs;
                    st_d.dat     = full_byte;
                    if (!rs && full_byte[DW-1:DW-3] == CFG_OPC) begin
                        st_d.wide = full_byte[CFG_WBIT];
                    end
                end else if (rs) begin
                    st_d.pop = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.wide <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid    = st_q.valid;
    assign is_data  = st_q.is_data;
    assign dat      = st_q.dat;
    assign pop      = st_q.pop;
    assign wide     = st_q.wide;
    assign lo_phase = st_q.lo_phase;

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    p_phase_upper_when_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wide |-> !st_q.lo_phase);
    p_narrow_second_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !$past(st_q.wide)) |-> $past(st_q.lo_phase));
    p_pop_never_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pop |-> !st_q.valid);
endmodule

// File: rtl/mbi_rdmux.sv
module mbi_rdmux
    import mbi_pkg::*;
(
    input  logic          en,
    input  logic          rs,
    input  logic          rw,
    input  logic          wide,
    input  logic          lo_phase,
    input  logic          busy,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          oe
);
    logic [DW-1:0] sel;

    always_comb begin
        sel = rs ? rdata : {busy, addr};
        oe  = en & rw;
        if (!oe)           dout = '0;
        else if (wide)     dout = sel;
        else if (lo_phase) dout = {sel[NW-1:0], {NW{1'b0}}};
        else               dout = {sel[DW-1:NW], {NW{1'b0}}};
    end
endmodule

// File: rtl/mpu_bus_front.sv
module mpu_bus_front
    import mbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_rs,
    input  logic          bus_rw,
    input  logic [DW-1:0] bus_d_in,
    output logic [DW-1:0] bus_d_out,
    output logic          bus_d_oe,
    input  logic          exec_busy,
    input  logic [AW-1:0] exec_addr,
    input  logic [DW-1:0] exec_rdata,
    output logic          cmd_valid,
    output logic          cmd_is_data,
    output logic [DW-1:0] cmd_byte,
    output logic          rdata_pop
);
    bus_smp_t raw, smp;
    logic     fall, wide, lo_phase;

    assign raw = '{en: bus_en, rs: bus_rs, rw: bus_rw, d: bus_d_in};

    mbi_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .smp(smp), .fall(fall)
    );

    mbi_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .fall(fall),
        .rs(smp.rs), .rw(smp.rw), .din(smp.d),
        .valid(cmd_valid), .is_data(cmd_is_data), .dat(cmd_byte),
        .pop(rdata_pop), .wide(wide), .lo_phase(lo_phase)
    );

    mbi_rdmux u_rdmux (
        .en(smp.en), .rs(smp.rs), .rw(smp.rw), .wide(wide), .lo_phase(lo_phase),
        .busy(exec_busy), .addr(exec_addr), .rdata(exec_rdata),
        .dout(bus_d_out), .oe(bus_d_oe)
    );

    p_oe_only_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> ($past(bus_rw, 2) && $past(bus_en, 2)));
    p_quiet_bus_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_d_oe |-> (bus_d_out == '0));
endmodule

// File: tb/tb_mpu_bus_front.sv
module tb_mpu_bus_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
    logic [7:0] bus_d_in = '0;
    logic [7:0] bus_d_out;
    logic       bus_d_oe;
    logic       exec_busy = 1'b0;
    logic [6:0] exec_addr = '0;
    logic [7:0] exec_rdata = '0;
    logic       cmd_valid, cmd_is_data, rdata_pop;
    logic [7:0] cmd_byte;

    always #4 clk = ~clk;   // 125 MHz

    mpu_bus_front dut (.*);

    typedef struct packed {
        logic        is_pop;
        logic        is_data;
        logic [7:0]  dat;
        int unsigned due;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          n_chk = 0, n_bad = 0;
    bit          narrow = 1'b0;   // bench's own model of the bus width
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: every delivery or pop must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || rdata_pop)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected pulse", {cmd_valid, rdata_pop, cmd_byte}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_pop) begin
                    chk(rdata_pop && !cmd_valid, "R5 pop", {cmd_valid, rdata_pop}, 1);
                end else begin
                    chk(cmd_valid && cmd_byte == e.dat && cmd_is_data == e.is_data,
                        e.is_data ? "R3 data byte" : "R2 instr byte",
                        {cmd_is_data, cmd_byte}, {e.is_data, e.dat});
                end
                chk(cyc == e.due, "R2 latency", int'(cyc), int'(e.due));
            end
        end
    end

    // one strobe; for reads checks oe/data while the strobe is high
    task automatic strobe(input bit rs, input bit rw, input logic [7:0] d,
                          input bit push, input bit pop_exp, input logic [7:0] rd_exp,
                          input string tag);
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_d_in = d;
        @(negedge clk);
        bus_en = 1'b1;
        repeat (4) @(negedge clk);
        if (rw) begin
            chk(bus_d_oe == 1'b1, "R9 oe on read", bus_d_oe, 1);
            chk(bus_d_out == rd_exp, tag, bus_d_out, rd_exp);
        end else begin
            chk(bus_d_oe == 1'b0, "R9 oe low on write", bus_d_oe, 0);
        end
        bus_en = 1'b0;
        if (push) sb.push_back('{is_pop: pop_exp, is_data: rs, dat: d, due: cyc + 3});
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input bit rs, input logic [7:0] b);
        if (narrow) begin
            strobe(rs, 1'b0, {b[7:4], 4'h0}, 1'b0, 1'b0, 8'h00, "R6");
            // first half alone must not deliver anything
            chk(sb.size() == 0 && !cmd_valid, "R6 no pulse after first half", cmd_valid, 0);
            @(negedge clk);
            bus_rs = rs; bus_rw = 1'b0; bus_d_in = {b[3:0], 4'h0};
            @(negedge clk); bus_en = 1'b1;
            repeat (4) @(negedge clk);
            bus_en = 1'b0;
            sb.push_back('{is_pop: 1'b0, is_data: rs, dat: b, due: cyc + 3});
            repeat (6) @(negedge clk);
        end else begin
            strobe(rs, 1'b0, b, 1'b1, 1'b0, 8'h00, "R2");
        end
        if (!rs && b[7:5] == 3'b001) narrow = ~b[4];   // R8 width model
    endtask

    task automatic rd(input bit rs, input logic [7:0] exp, input string tag);
        if (narrow) begin
            strobe(rs, 1'b1, 8'h00, 1'b0, 1'b0, {exp[7:4], 4'h0}, {tag, " R7 upper"});
            strobe(rs, 1'b1, 8'h00, rs, 1'b1, {exp[3:0], 4'h0}, {tag, " R7 lower"});
        end else begin
            strobe(rs, 1'b1, 8'h00, rs, 1'b1, exp, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cmd_valid && !rdata_pop, "R1 no pulses", {cmd_valid, rdata_pop}, 0);
        chk(!bus_d_oe && bus_d_out == 8'h00, "R1 bus quiet", {bus_d_oe, bus_d_out}, 0);

        // R2 / R3 eight-bit writes
        wr(1'b0, 8'h38);
        wr(1'b0, 8'h0C);
        wr(1'b1, 8'hA5);
        wr(1'b1, 8'h5A);

        // R4 / R10 status read returns busy+addr, not the last instruction
        exec_busy = 1'b1; exec_addr = 7'h2B;
        rd(1'b0, 8'hAB, "R4 R10 status");
        exec_busy = 1'b0; exec_addr = 7'h05;
        rd(1'b0, 8'h05, "R4 status idle");

        // R5 data read with pop
        exec_rdata = 8'hC3;
        rd(1'b1, 8'hC3, "R5 data read");

        // R8 switch to four bits with a single eight-bit strobe
        wr(1'b0, 8'h20);
        // R6 four-bit writes
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'h7E);
        // R7 four-bit reads
        exec_busy = 1'b0; exec_addr = 7'h45;
        rd(1'b0, 8'h45, "R7 status");
        exec_rdata = 8'h9B;
        rd(1'b1, 8'h9B, "R7 data");
        // R8 configuration with width bit 0 keeps four bits
        wr(1'b0, 8'h28);
        wr(1'b1, 8'hE1);
        // R8 back to eight bits from four-bit mode
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h11);
        exec_busy = 1'b1; exec_addr = 7'h7F;
        rd(1'b0, 8'hFF, "R4 status full");

        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R2 all deliveries seen", sb.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule